// File: doc/BRIEF.md
# I2C Serial Clock Generator with Prescaled Phase Timing

This block makes the serial clock (SCL) waveform of an I2C master from the system clock. A prescaler divides the system clock into a module-clock tick, one tick every `psc_val + 1` system cycles. Each SCL low phase lasts `low_cnt + pad` ticks and each high phase lasts `high_cnt + pad` ticks. The fixed pad depends on the prescaler setting: 7 ticks for a prescaler of 0, 6 for a prescaler of 1, and 5 for any larger value. Software chooses the prescaler so that the module clock falls in the 7 to 12 MHz range. Meeting that range is the integrator's job and is not checked here.

The bit engine drives `run_req` to ask for bus cycles and receives one-cycle strobes on each SCL rising and falling transition. While `enable` is low the generator is parked: SCL is released high and no strobes are issued. The divider values are captured freely while parked and during the idle state. While running they are captured only at phase boundaries, so a change applies from the next phase on. A build-time option adds clock-stretch support. With it, the count of a high phase is frozen while the synchronised bus line reads low.

Top module: `scl_clkgen`

## Requirements
- R1: After reset, `scl_o` is 1 and both `rise_stb` and `fall_stb` are 0.
- R2: The module-clock tick repeats every `psc_val + 1` system cycles, so every phase length in system cycles is a whole multiple of `psc_val + 1`.
- R3: The spacing from a `fall_stb` to the next `rise_stb` is `(low_cnt + pad) * (psc_val + 1)` system cycles.
- R4: Without stretching, the spacing from a `rise_stb` to the next `fall_stb` in continuous running is `(high_cnt + pad) * (psc_val + 1)` system cycles.
- R5: pad is 7 when `psc_val` is 0, 6 when it is 1, and 5 when it is 2 or more; no phase is shorter than 5 system cycles.
- R6: While `enable` is 0 the block goes idle on the next clock edge: `scl_o` is 1, no strobes are issued, and the divider inputs are captured.
- R7: From idle, SCL goes low only on a request: `fall_stb` appears one cycle after `run_req` is seen high. If `run_req` is 0 when a high phase ends, SCL stays high and the block returns to idle.
- R8: Each strobe is one system cycle wide. `fall_stb` coincides with `scl_o` turning 0 and `rise_stb` with `scl_o` turning 1. The two strobes are never high together, and `scl_o` never changes without a strobe unless the block is disabled.
- R9: A change to `low_cnt`, `high_cnt` or `psc_val` while running does not alter the phase in progress. It applies from the next phase boundary.
- R10: With `STRETCH_EN = 0`, `scl_in` has no effect on any output.
- R11: With `STRETCH_EN = 1`, the high-phase count is frozen in every cycle where the line, after `SYNC_STAGES` flops, reads low. A free line therefore adds `SYNC_STAGES` cycles to each high phase. After a slave releases the line, the next `fall_stb` comes `(high_cnt + pad) * (psc_val + 1) + SYNC_STAGES` cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Module enable; 0 parks the generator idle |
| run_req | input | 1 | Bit-engine request for bus cycles |
| psc_val | input | PSC_W | Prescaler setting (tick every psc_val+1 cycles) |
| low_cnt | input | CNT_W | Low-phase count, before the pad |
| high_cnt | input | CNT_W | High-phase count, before the pad |
| scl_in | input | 1 | Sensed bus SCL level (used only when stretching) |
| scl_o | output | 1 | SCL drive level, 1 = released high |
| rise_stb | output | 1 | One-cycle strobe on an SCL low-to-high transition |
| fall_stb | output | 1 | One-cycle strobe on an SCL high-to-low transition |

## Verification
The properties assume that `enable` and `run_req` are synchronous to `clk` and that every phase count is large enough for the pad of at least 5 to dominate. The minimum-phase property relies on that pad together with the one-tick-per-cycle lower bound. The bench changes every input only at the falling clock edge. It alters the divider values either while the block is disabled or mid-phase, where the result is defined. On the stretching instance it drives the sensed line as the generator's own output combined with a slave hold, so the line is never high while the generator drives it low.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_HIGH = 2'd2
   } phase_e;

   localparam int unsigned PAD_W         = 3;
   localparam int unsigned PAD_PSC_ZERO  = 7;
   localparam int unsigned PAD_PSC_ONE   = 6;
   localparam int unsigned PAD_PSC_WIDE  = 5;

   // Extra ticks added to every phase, chosen from the prescaler setting.
   function automatic logic [PAD_W-1:0] phase_pad(input logic psc_is_zero,
                                                  input logic psc_is_one);
      if (psc_is_zero)
         return PAD_W'(PAD_PSC_ZERO);
      else if (psc_is_one)
         return PAD_W'(PAD_PSC_ONE);
      else
         return PAD_W'(PAD_PSC_WIDE);
   endfunction

endpackage

// File: rtl/scl_tick_div.sv
// Prescaler: emits a tick when the count reaches the limit; frozen by hold.
module scl_tick_div #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         hold,
   input  logic [W-1:0] limit,
   output logic         tick
);

   logic [W-1:0] cnt_q;

   assign tick = !hold && (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (hold)
         cnt_q <= cnt_q;
      else if (tick)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + W'(1);
   end

endmodule

// File: rtl/scl_phase_cnt.sv
// Counts module ticks within one SCL phase; flags the last tick.
module scl_phase_cnt #(
   parameter int W = 17
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         step,
   input  logic [W-1:0] len,
   output logic         last
);

   logic [W-1:0] cnt_q;

   assign last = step && (cnt_q == (len - W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr || last)
         cnt_q <= '0;
      else if (step)
         cnt_q <= cnt_q + W'(1);
   end

endmodule

// File: rtl/scl_line_in.sv
// Optional synchroniser for the sensed bus clock line.
module scl_line_in #(
   parameter int STRETCH_EN  = 0,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   output logic line_hi
);

   generate
      if (STRETCH_EN != 0) begin : g_sync
         logic [SYNC_STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               sh_q <= '1;
            else
               sh_q <= {sh_q[SYNC_STAGES-2:0], scl_in};
         end
         assign line_hi = sh_q[SYNC_STAGES-1];
      end else begin : g_nosync
         logic unused_in;
         assign unused_in = clk ^ rst_n ^ scl_in;
         assign line_hi   = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen
   import scl_gen_pkg::*;
#(
   parameter int PSC_W       = 16,
   parameter int CNT_W       = 16,
   parameter int STRETCH_EN  = 0,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             run_req,
   input  logic [PSC_W-1:0] psc_val,
   input  logic [CNT_W-1:0] low_cnt,
   input  logic [CNT_W-1:0] high_cnt,
   input  logic             scl_in,
   output logic             scl_o,
   output logic             rise_stb,
   output logic             fall_stb
);

   localparam int LEN_W = CNT_W + 1;

   generate
      if (PSC_W < 1 || PSC_W > 32) begin : g_bad_psc
         $error("scl_clkgen: PSC_W must be 1..32");
      end
      if (CNT_W < 3 || CNT_W > 30) begin : g_bad_cnt
         $error("scl_clkgen: CNT_W must be 3..30");
      end
      if (STRETCH_EN != 0 && SYNC_STAGES < 2) begin : g_bad_sync
         $error("scl_clkgen: SYNC_STAGES must be at least 2");
      end
   endgenerate

   phase_e             phase_q;
   logic               scl_q, rise_q, fall_q;
   logic [PSC_W-1:0]   psc_sh;
   logic [CNT_W-1:0]   low_sh, high_sh;
   logic               tick, last_raw, seg_end, restart, hold, line_hi;
   logic [PAD_W-1:0]   pad;
   logic [LEN_W-1:0]   len;

   // Divider shadows: follow the inputs while idle or parked, and
   // re-capture only when a phase ends.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psc_sh  <= '0;
         low_sh  <= '0;
         high_sh <= '0;
      end else if (restart) begin
         psc_sh  <= psc_val;
         low_sh  <= low_cnt;
         high_sh <= high_cnt;
      end
   end

   assign pad = phase_pad(psc_sh == '0, psc_sh == PSC_W'(1));
   assign len = ((phase_q == PH_HIGH) ? {1'b0, high_sh} : {1'b0, low_sh})
                + LEN_W'(pad);

   assign seg_end = last_raw && enable && (phase_q != PH_IDLE);
   assign restart = !enable || (phase_q == PH_IDLE) || seg_end;
   assign hold    = (phase_q == PH_HIGH) && !line_hi;

   scl_line_in #(
      .STRETCH_EN  (STRETCH_EN),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_line (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_in  (scl_in),
      .line_hi (line_hi)
   );

   scl_tick_div #(.W(PSC_W)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (restart),
      .hold  (hold),
      .limit (psc_sh),
      .tick  (tick)
   );

   scl_phase_cnt #(.W(LEN_W)) u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (restart),
      .step  (tick),
      .len   (len),
      .last  (last_raw)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         scl_q   <= 1'b1;
         rise_q  <= 1'b0;
         fall_q  <= 1'b0;
      end else begin
         rise_q <= 1'b0;
         fall_q <= 1'b0;
         if (!enable) begin
            phase_q <= PH_IDLE;
            scl_q   <= 1'b1;
         end else begin
            case (phase_q)
               PH_IDLE: begin
                  if (run_req) begin
                     phase_q <= PH_LOW;
                     scl_q   <= 1'b0;
                     fall_q  <= 1'b1;
                  end
               end
               PH_LOW: begin
                  if (seg_end) begin
                     phase_q <= PH_HIGH;
                     scl_q   <= 1'b1;
                     rise_q  <= 1'b1;
                  end
               end
               PH_HIGH: begin
                  if (seg_end) begin
                     if (run_req) begin
                        phase_q <= PH_LOW;
                        scl_q   <= 1'b0;
                        fall_q  <= 1'b1;
                     end else begin
                        phase_q <= PH_IDLE;
                     end
                  end
               end
               default: begin
                  phase_q <= PH_IDLE;
                  scl_q   <= 1'b1;
               end
            endcase
         end
      end
   end

   assign scl_o    = scl_q;
   assign rise_stb = rise_q;
   assign fall_stb = fall_q;

endmodule

// File: rtl/scl_clkgen_chk.sv
module scl_clkgen_chk (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic run_req,
   input logic scl_o,
   input logic rise_stb,
   input logic fall_stb
);

   logic [15:0] gap_q;
   logic        seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else if (!enable) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else if (rise_stb || fall_stb) begin
         gap_q  <= '0;
         seen_q <= 1'b1;
      end else if (gap_q != 16'hFFFF) begin
         gap_q  <= gap_q + 16'd1;
      end
   end

   a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise_stb && fall_stb));

   a_r8_rise_level: assert property (@(posedge clk) disable iff (!rst_n)
      rise_stb |-> scl_o);

   a_r8_fall_level: assert property (@(posedge clk) disable iff (!rst_n)
      fall_stb |-> !scl_o);

   a_r8_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
      rise_stb |=> !rise_stb);

   a_r8_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
      fall_stb |=> !fall_stb);

   a_r8_change_marked: assert property (@(posedge clk) disable iff (!rst_n)
      ((scl_o != $past(scl_o)) && $past(enable)) |-> (rise_stb || fall_stb));

   a_r6_parked: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (scl_o && !rise_stb && !fall_stb));

   a_r7_fall_requested: assert property (@(posedge clk) disable iff (!rst_n)
      fall_stb |-> $past(run_req));

   a_r5_min_phase: assert property (@(posedge clk) disable iff (!rst_n)
      ((rise_stb || fall_stb) && seen_q) |-> (gap_q >= 16'd4));

endmodule

bind scl_clkgen scl_clkgen_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .enable   (enable),
   .run_req  (run_req),
   .scl_o    (scl_o),
   .rise_stb (rise_stb),
   .fall_stb (fall_stb)
);

// File: tb/scl_clkgen_tb.sv
`timescale 1ns/1ps
module scl_clkgen_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic        run_req = 1'b0;
   logic [15:0] psc_val = '0;
   logic [15:0] low_cnt = '0;
   logic [15:0] high_cnt = '0;
   logic        slave_hold = 1'b0;
   logic        scl_o, rise_stb, fall_stb;
   logic        scl_s, rise_s, fall_s, scl_in_s;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   // R10: the plain instance sees a line stuck low
   scl_clkgen u_dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .run_req(run_req),
      .psc_val(psc_val), .low_cnt(low_cnt), .high_cnt(high_cnt),
      .scl_in(1'b0), .scl_o(scl_o), .rise_stb(rise_stb), .fall_stb(fall_stb)
   );

   assign scl_in_s = scl_s & ~slave_hold;

   scl_clkgen #(.STRETCH_EN(1), .SYNC_STAGES(2)) u_dut_str (
      .clk(clk), .rst_n(rst_n), .enable(enable), .run_req(run_req),
      .psc_val(psc_val), .low_cnt(low_cnt), .high_cnt(high_cnt),
      .scl_in(scl_in_s), .scl_o(scl_s), .rise_stb(rise_s), .fall_stb(fall_s)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic sig(input int which);
      case (which)
         0: return fall_stb;
         1: return rise_stb;
         2: return fall_s;
         default: return rise_s;
      endcase
   endfunction

   // counts falling edges until the selected strobe is seen
   task automatic wait_ev(input int which, output int n);
      n = 0;
      forever begin
         @(negedge clk);
         n++;
         if (sig(which)) break;
         if (n >= 5000) begin n = -1; break; end
      end
   endtask

   function automatic int pad_of(input int psc);
      return (psc == 0) ? 7 : (psc == 1) ? 6 : 5;
   endfunction

   task automatic prep(input int psc, input int lo, input int hi);
      @(negedge clk);
      enable = 1'b0; run_req = 1'b0; slave_hold = 1'b0;
      psc_val = 16'(psc); low_cnt = 16'(lo); high_cnt = 16'(hi);
      repeat (3) @(negedge clk);
      enable = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R1 scl after reset", int'(scl_o), 1);
      chk("R1 rise after reset", int'(rise_stb), 0);
      chk("R1 fall after reset", int'(fall_stb), 0);
   endtask

   task automatic t_idle_no_request;
      int strobes = 0;
      int lows = 0;
      prep(0, 2, 2);
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (rise_stb || fall_stb) strobes++;
         if (!scl_o) lows++;
      end
      chk("R7 no strobe without request", strobes, 0);
      chk("R7 scl stays high without request", lows, 0);
   endtask

   task automatic t_period(input int psc, input int lo, input int hi);
      int n;
      int d = pad_of(psc);
      prep(psc, lo, hi);
      run_req = 1'b1;
      wait_ev(0, n);
      chk("R7 fall one cycle after request", n, 1);
      chk("R8 scl low with fall strobe", int'(scl_o), 0);
      wait_ev(1, n);
      chk($sformatf("R3 R5 R2 low span psc=%0d", psc), n, (lo + d) * (psc + 1));
      chk("R8 scl high with rise strobe", int'(scl_o), 1);
      @(negedge clk);
      chk("R8 rise strobe one cycle wide", int'(rise_stb), 0);
      wait_ev(0, n);
      chk($sformatf("R4 R5 R2 high span psc=%0d", psc), n + 1, (hi + d) * (psc + 1));
   endtask

   task automatic t_disable;
      int bad = 0;
      int n;
      prep(0, 6, 6);
      run_req = 1'b1;
      wait_ev(0, n);
      repeat (3) @(negedge clk);
      enable = 1'b0;
      @(negedge clk);
      chk("R6 scl released when disabled", int'(scl_o), 1);
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (rise_stb || fall_stb || !scl_o) bad++;
      end
      chk("R6 no activity while disabled", bad, 0);
   endtask

   task automatic t_stop;
      int n;
      int bad = 0;
      prep(1, 2, 3);
      run_req = 1'b1;
      wait_ev(1, n);
      run_req = 1'b0;
      for (int i = 0; i < 120; i++) begin
         @(negedge clk);
         if (fall_stb || rise_stb || !scl_o) bad++;
      end
      chk("R7 idle after high phase without request", bad, 0);
      run_req = 1'b1;
      wait_ev(0, n);
      chk("R7 restart from idle", n, 1);
   endtask

   task automatic t_midchange;
      int n;
      prep(0, 3, 3);
      run_req = 1'b1;
      wait_ev(0, n);
      low_cnt = 16'd12; high_cnt = 16'd9;
      wait_ev(1, n);
      chk("R9 current low keeps old count", n, 10);
      wait_ev(0, n);
      chk("R9 next high uses new count", n, 16);
      wait_ev(1, n);
      chk("R9 next low uses new count", n, 19);
   endtask

   task automatic t_stretch;
      int n;
      int early = 0;
      prep(0, 3, 3);
      run_req = 1'b1;
      wait_ev(2, n);
      wait_ev(3, n);
      chk("R11 low phase unaffected by stretch option", n, 10);
      wait_ev(2, n);
      chk("R11 free line adds sync delay to high", n, 12);
      wait_ev(3, n);
      slave_hold = 1'b1;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (fall_s) early++;
      end
      chk("R11 no fall while slave holds line", early, 0);
      slave_hold = 1'b0;
      wait_ev(2, n);
      chk("R11 fall after release", n, 12);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_idle_no_request();
      t_period(0, 2, 4);
      t_period(1, 3, 1);
      t_period(2, 0, 2);
      t_period(5, 4, 6);
      t_disable();
      t_stop();
      t_midchange();
      t_stretch();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog (all requirements) actual=hang expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule